// File: doc/BRIEF.md
# Dual-Law PCM Compander

This block converts signed 13-bit linear voice samples into 8-bit companded PCM words and turns PCM words back into linear samples. A static select input picks the companding law, either Mu-255 or A-law. Both laws share one datapath: a magnitude stage, a leading-one search that finds the segment (chord), a shifter that extracts the four step bits, and a final inversion pattern that is specific to each law. Because of that last stage the zero and full-scale codes differ between the two laws.

The two directions run on their own. Each has a valid/ready handshake on its input and on its output and a single register stage, and each carries one sample per transaction. Expansion returns the midpoint of the step interval that the code selects. Magnitudes beyond the top step clip to the full-scale code of their sign and never wrap.

Top module: `pcm_compander`

## Requirements
- R1: `law_sel` = 0 selects Mu-255 law and 1 selects A-law, and it is held steady while traffic flows. Before the law's inversion a word is {sign, chord[2:0], step[3:0]}, with sign in bit 7, chord in bits 6:4 and step in bits 3:0. Sign is 1 for an input that is zero or positive.
- R2: Mu-law encode takes m = 2*|x|, clips m at 8158 and adds 33. The chord is the bit index of the leading one of that biased value minus 5. The step is the four bits just below the leading one. The transmitted word is the pre-inversion word with bits 6:0 inverted.
- R3: A-law encode clips |x| at 4095. Below 32 the chord is 0 and the step is |x|>>1. Otherwise the chord is the leading-one index of |x| minus 4 and the step is the four bits below the leading one. The transmitted word is the pre-inversion word XOR 0x55.
- R4: In Mu-law, input 0 encodes as 0xFF, 4095 as 0x80 and -4096 as 0x00.
- R5: In A-law, input 0 encodes as 0xD5, -1 as 0x55, 4095 as 0xAA and -4096 as 0x2A.
- R6: Large magnitudes clip to the full-scale code of their sign. In Mu-law every |x| >= 3952 gives 0x80 (positive) or 0x00 (negative). In A-law every |x| >= 3968 gives 0xAA or 0x2A.
- R7: Mu-law decode inverts bits 6:0 to recover chord c and step s. The result magnitude is floor((((2s+33)<<c) - 33)/2), negated when bit 7 is 0.
- R8: A-law decode XORs the code with 0x55. Chord 0 gives magnitude 2s+1 and chord c >= 1 gives (2s+33)<<(c-1). The result is negated when bit 7 is 0.
- R9: A path accepts a sample when its input valid and ready are both high at a clock edge, and presents the result with output valid on the next cycle. Out of reset, input ready equals (not output valid) or output ready.
- R10: While an output valid is high and its ready is low, that valid stays high and the data stays unchanged.
- R11: While reset is asserted, both output valids and both input readies are low. A few cycles after release, the readies are high and the valids are still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_sel | input | 1 | Law select: 0 Mu-law, 1 A-law |
| enc_in_valid | input | 1 | Linear sample offered |
| enc_in_ready | output | 1 | Encoder can accept a sample |
| enc_in_lin | input | 13 | Linear sample, two's complement |
| enc_out_valid | output | 1 | PCM code available |
| enc_out_ready | input | 1 | Consumer takes the PCM code |
| enc_out_code | output | 8 | Companded PCM word |
| dec_in_valid | input | 1 | PCM word offered |
| dec_in_ready | output | 1 | Decoder can accept a word |
| dec_in_code | input | 8 | PCM word to expand |
| dec_out_valid | output | 1 | Linear result available |
| dec_out_ready | input | 1 | Consumer takes the linear result |
| dec_out_lin | output | 13 | Expanded linear sample, two's complement |

## Verification
The hardest situations to reach from the ports are the exact clip edges and a step boundary in the same cycle that the output is stalled while a new sample waits at the input. To get there, the stimulus sweeps every one of the 8192 linear codes and all 256 PCM codes under each law. Valid gaps and output-ready drops are random throughout the sweep, so each boundary value is also seen under backpressure. The landmark codes are compared against literal values rather than against the bench model.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int LIN_W   = 13;
  localparam int CHORD_W = 3;
  localparam int STEP_W  = 4;
  localparam int CODE_W  = 1 + CHORD_W + STEP_W;
  // bias used by the Mu-law search and the midpoint constant of both laws
  localparam int SEG_K   = (1 << (STEP_W + 1)) + 1;
  localparam logic [CODE_W-1:0] A_FLIP  = 8'h55;
  localparam logic [CODE_W-1:0] MU_FLIP = 8'h7F;

  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  typedef struct packed {
    logic               sign;
    logic [CHORD_W-1:0] chord;
    logic [STEP_W-1:0]  step;
  } pcm_word_t;
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pcm_lead_one.sv
module pcm_lead_one #(
  parameter int W  = 13,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);
  // highest set bit wins; zero vector reports position 0
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/pcm_encode.sv
module pcm_encode
  import pcm_pkg::*;
#(
  parameter int LW = LIN_W
) (
  input  law_e              law,
  input  logic [LW-1:0]     lin,
  output logic [CODE_W-1:0] code
);
  localparam int EXT_W     = LW + 1;
  localparam int MU_CLIP   = (1 << LW) - 1 - SEG_K;
  localparam int A_CLIP    = (1 << (LW - 1)) - 1;
  localparam int PW        = $clog2(LW);
  localparam int CHORD_OFS = LW - (1 << CHORD_W);

  logic               neg;
  logic [LW-1:0]      mag;
  logic [EXT_W-1:0]   mag_ext;
  logic [EXT_W-1:0]   mag_ext_clip;
  logic [LW-1:0]      mu_biased;
  logic [LW-1:0]      a_mag;
  logic [LW-1:0]      a_vec;
  logic [LW-1:0]      srch;
  logic [PW-1:0]      lead_pos;
  logic [CHORD_W-1:0] chord;
  logic [PW-1:0]      shamt;
  logic [STEP_W-1:0]  step;
  pcm_word_t          raw;

  always_comb begin
    neg          = lin[LW-1];
    mag          = neg ? (~lin + 1'b1) : lin;
    mag_ext      = {mag, 1'b0};
    mag_ext_clip = (mag_ext > EXT_W'(MU_CLIP)) ? EXT_W'(MU_CLIP) : mag_ext;
    mu_biased    = LW'(mag_ext_clip + EXT_W'(SEG_K));
    a_mag        = (mag > LW'(A_CLIP)) ? LW'(A_CLIP) : mag;
    a_vec        = LW'({a_mag, 1'b0});
    srch         = (law == LAW_A) ? a_vec : mu_biased;
  end

  pcm_lead_one #(.W(LW), .PW(PW)) u_lead (
    .vec (srch),
    .pos (lead_pos)
  );

  always_comb begin
    chord = (lead_pos > PW'(CHORD_OFS)) ? CHORD_W'(lead_pos - PW'(CHORD_OFS)) : '0;
    shamt = (law == LAW_A && chord == '0) ? PW'(2) : (PW'(chord) + PW'(1));
    step  = STEP_W'(srch >> shamt);
    raw.sign  = ~neg;
    raw.chord = chord;
    raw.step  = step;
    code = (law == LAW_A) ? (raw ^ A_FLIP) : (raw ^ MU_FLIP);
  end
endmodule

// File: rtl/pcm_decode.sv
module pcm_decode
  import pcm_pkg::*;
#(
  parameter int LW = LIN_W
) (
  input  law_e              law,
  input  logic [CODE_W-1:0] code,
  output logic [LW-1:0]     lin
);
  localparam int EXT_W = LW + 1;

  pcm_word_t        fld;
  logic [EXT_W-1:0] base;
  logic [EXT_W-1:0] scaled;
  logic [EXT_W-1:0] mu_mag;
  logic [EXT_W-1:0] a_mag;
  logic [LW-1:0]    mag;

  always_comb begin
    fld    = (law == LAW_A) ? pcm_word_t'(code ^ A_FLIP) : pcm_word_t'(code ^ MU_FLIP);
    base   = EXT_W'({fld.step, 1'b0}) + EXT_W'(SEG_K);
    scaled = base << fld.chord;
    mu_mag = (scaled - EXT_W'(SEG_K)) >> 1;
    a_mag  = (fld.chord == '0) ? EXT_W'({fld.step, 1'b1}) : (scaled >> 1);
    mag    = LW'((law == LAW_A) ? a_mag : mu_mag);
    lin    = fld.sign ? mag : (~mag + 1'b1);
  end
endmodule

// File: rtl/pcm_stage.sv
module pcm_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic         vld_d;
  logic         load;
  logic [W-1:0] dat_q;

  always_comb begin
    in_ready = rst_n && (!vld_q || out_ready);
    load     = in_valid && in_ready;
    vld_d    = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/pcm_compander.sv
module pcm_compander
  import pcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              law_sel,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [LIN_W-1:0]  enc_in_lin,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_code,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [LIN_W-1:0]  dec_out_lin
);
  law_e              law;
  logic              rst_n_int;
  logic [CODE_W-1:0] enc_code_c;
  logic [LIN_W-1:0]  dec_lin_c;

  assign law = law_e'(law_sel);

  pcm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pcm_encode #(.LW(LIN_W)) u_enc (
    .law  (law),
    .lin  (enc_in_lin),
    .code (enc_code_c)
  );

  pcm_stage #(.W(CODE_W)) u_enc_stage (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_code_c),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_code)
  );

  pcm_decode #(.LW(LIN_W)) u_dec (
    .law  (law),
    .code (dec_in_code),
    .lin  (dec_lin_c)
  );

  pcm_stage #(.W(LIN_W)) u_dec_stage (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_lin_c),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_out_lin)
  );
endmodule

// File: rtl/pcm_compander_chk.sv
module pcm_compander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        law_sel,
  input logic        enc_in_valid,
  input logic        enc_in_ready,
  input logic [12:0] enc_in_lin,
  input logic        enc_out_valid,
  input logic        enc_out_ready,
  input logic [7:0]  enc_out_code,
  input logic        dec_in_valid,
  input logic        dec_in_ready,
  input logic [7:0]  dec_in_code,
  input logic        dec_out_valid,
  input logic        dec_out_ready,
  input logic [12:0] dec_out_lin
);
  logic enc_take;
  logic dec_take;
  assign enc_take = enc_in_valid && enc_in_ready;
  assign dec_take = dec_in_valid && dec_in_ready;

  assert_enc_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enc_take |=> enc_out_valid);
  assert_dec_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_take |=> dec_out_valid);
  assert_enc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_out_valid && !enc_out_ready) |=> (enc_out_valid && $stable(enc_out_code)));
  assert_dec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && !dec_out_ready) |=> (dec_out_valid && $stable(dec_out_lin)));
  assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_take && !enc_in_lin[12]) |=> enc_out_code[7]);
  assert_mu_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_take && !law_sel && enc_in_lin == 13'd0) |=> (enc_out_code == 8'hFF));
  assert_a_negfs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_take && law_sel && enc_in_lin == 13'h1000) |=> (enc_out_code == 8'h2A));
  assert_mu_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_take && !law_sel && $signed(enc_in_lin) >= 13'sd3952) |=> (enc_out_code == 8'h80));
  assert_mu_dec_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_take && !law_sel && dec_in_code == 8'hFF) |=> (dec_out_lin == 13'd0));
  assert_a_dec_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_take && law_sel && dec_in_code == 8'hD5) |=> (dec_out_lin == 13'd1));
endmodule

bind pcm_compander pcm_compander_chk u_chk (.*);

// File: tb/sim_pcm_compander.sv
module sim_pcm_compander;
  logic        clk;
  logic        rst_n;
  logic        law_sel;
  logic        enc_in_valid;
  logic        enc_in_ready;
  logic [12:0] enc_in_lin;
  logic        enc_out_valid;
  logic        enc_out_ready;
  logic [7:0]  enc_out_code;
  logic        dec_in_valid;
  logic        dec_in_ready;
  logic [7:0]  dec_in_code;
  logic        dec_out_valid;
  logic        dec_out_ready;
  logic [12:0] dec_out_lin;

  int  n_chk;
  int  n_fail;
  bit  done;

  pcm_compander u0 (.*);

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural encoder model
  function automatic logic [7:0] model_enc(input int x, input bit alaw);
    int m, b, c, st, w;
    bit pos;
    pos = (x >= 0);
    m   = pos ? x : -x;
    if (!alaw) begin
      m = 2 * m;
      if (m > 8158) m = 8158;
      b = m + 33;
      c = 0;
      while (b >= (64 << c)) c++;
      st = (b >> (c + 1)) & 15;
      w  = (int'(pos) << 7) | (c << 4) | st;
      return 8'(w ^ 'h7F);
    end
    if (m > 4095) m = 4095;
    c = 0;
    if (m >= 32) begin
      c = 1;
      while (m >= (64 << (c - 1))) c++;
    end
    st = (c == 0) ? (m >> 1) : ((m >> c) & 15);
    w  = (int'(pos) << 7) | (c << 4) | st;
    return 8'(w ^ 'h55);
  endfunction

  // literal landmark codes (R4, R5, R6); returns -1 when none applies
  function automatic int landmark(input int x, input bit alaw);
    if (!alaw) begin
      if (x == 0) return 'hFF;
      if (x == 4095) return 'h80;
      if (x == -4096) return 'h00;
      if (x >= 3952) return 'h80;
      if (x <= -3952) return 'h00;
    end else begin
      if (x == 0) return 'hD5;
      if (x == -1) return 'h55;
      if (x == 4095) return 'hAA;
      if (x == -4096) return 'h2A;
      if (x >= 3968) return 'hAA;
      if (x <= -3968) return 'h2A;
    end
    return -1;
  endfunction

  function automatic string enc_tag(input int x, input bit alaw);
    if (x >= 3952 || x <= -3952) begin
      if (x == 4095 || x == -4096) return alaw ? "R5" : "R4";
      return "R6";
    end
    if (x == 0 || (alaw && x == -1)) return alaw ? "R5" : "R4";
    return alaw ? "R3" : "R2";
  endfunction

  // behavioural decoder model: midpoint of the step interval
  function automatic logic [12:0] model_dec(input logic [7:0] code, input bit alaw);
    int f, c, s, lo, wd, mid;
    f = alaw ? int'(code ^ 8'h55) : int'(code ^ 8'h7F);
    c = (f >> 4) & 7;
    s = f & 15;
    if (!alaw) begin
      lo  = (16 + s) << (c + 1);
      wd  = 1 << (c + 1);
      mid = ((lo + lo + wd) / 2 - 33) / 2;
    end else if (c == 0) begin
      mid = 2 * s + 1;
    end else begin
      lo  = (16 + s) << c;
      mid = lo + ((1 << c) / 2);
    end
    if (((f >> 7) & 1) == 0) mid = -mid;
    return 13'(mid);
  endfunction

  task automatic run_law(input bit alaw);
    int          enc_idx;
    int          dec_idx;
    bit          enc_fire, dec_fire, enc_exp_v, dec_exp_v, enc_stall, dec_stall;
    logic [7:0]  enc_prev;
    logic [12:0] dec_prev;
    logic [7:0]  qc[$];
    string       qt[$];
    logic [12:0] ql[$];
    int          lm;
    enc_idx = 0; dec_idx = 0;
    enc_fire = 0; dec_fire = 0; enc_exp_v = 0; dec_exp_v = 0;
    enc_stall = 0; dec_stall = 0; enc_prev = '0; dec_prev = '0;
    law_sel = alaw;
    rst_n = 1'b0;
    enc_in_valid = 0; dec_in_valid = 0; enc_out_ready = 0; dec_out_ready = 0;
    enc_in_lin = '0; dec_in_code = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!enc_out_valid && !dec_out_valid, "R11", {enc_out_valid, dec_out_valid}, 0);
    check(!enc_in_ready && !dec_in_ready, "R11", {enc_in_ready, dec_in_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!enc_out_valid && !dec_out_valid, "R11", {enc_out_valid, dec_out_valid}, 0);
    check(enc_in_ready && dec_in_ready, "R11", {enc_in_ready, dec_in_ready}, 3);

    while (enc_idx < 8192 || dec_idx < 256 || enc_in_valid || dec_in_valid ||
           qc.size() > 0 || ql.size() > 0) begin
      @(negedge clk);
      if (enc_fire) enc_in_valid = 1'b0;
      if (dec_fire) dec_in_valid = 1'b0;
      enc_out_ready = ($urandom_range(3) != 0);
      dec_out_ready = ($urandom_range(3) != 0);
      if (!enc_in_valid && enc_idx < 8192 && $urandom_range(4) != 0) begin
        enc_in_lin   = 13'(enc_idx - 4096);
        enc_in_valid = 1'b1;
        enc_idx++;
      end
      if (!dec_in_valid && dec_idx < 256 && $urandom_range(4) != 0) begin
        dec_in_code  = 8'(dec_idx);
        dec_in_valid = 1'b1;
        dec_idx++;
      end
      #1;
      if (enc_exp_v) check(enc_out_valid, "R9", enc_out_valid, 1);
      if (dec_exp_v) check(dec_out_valid, "R9", dec_out_valid, 1);
      if (enc_stall) check(enc_out_valid && enc_out_code == enc_prev, "R10", enc_out_code, enc_prev);
      if (dec_stall) check(dec_out_valid && dec_out_lin == dec_prev, "R10", dec_out_lin, dec_prev);
      check(enc_in_ready == (!enc_out_valid || enc_out_ready), "R9", enc_in_ready, !enc_out_valid || enc_out_ready);
      check(dec_in_ready == (!dec_out_valid || dec_out_ready), "R9", dec_in_ready, !dec_out_valid || dec_out_ready);

      enc_fire = enc_in_valid && enc_in_ready;
      dec_fire = dec_in_valid && dec_in_ready;
      if (enc_fire) begin
        lm = landmark($signed(enc_in_lin), alaw);
        qc.push_back((lm >= 0) ? 8'(lm) : model_enc($signed(enc_in_lin), alaw));
        qt.push_back(enc_tag($signed(enc_in_lin), alaw));
      end
      if (dec_fire) ql.push_back(model_dec(dec_in_code, alaw));

      if (enc_out_valid && enc_out_ready) begin
        if (qc.size() == 0) check(1'b0, "R9", enc_out_code, 0);
        else begin
          logic [7:0] e;
          string      t;
          e = qc.pop_front();
          t = qt.pop_front();
          check(enc_out_code == e, t, enc_out_code, e);
        end
      end
      if (dec_out_valid && dec_out_ready) begin
        if (ql.size() == 0) check(1'b0, "R9", dec_out_lin, 0);
        else begin
          logic [12:0] e;
          e = ql.pop_front();
          check(dec_out_lin == e, alaw ? "R8" : "R7", dec_out_lin, e);
        end
      end
      enc_exp_v = enc_fire;
      dec_exp_v = dec_fire;
      enc_stall = enc_out_valid && !enc_out_ready;
      dec_stall = dec_out_valid && !dec_out_ready;
      enc_prev  = enc_out_code;
      dec_prev  = dec_out_lin;
    end
    @(negedge clk);
    enc_in_valid = 1'b0;
    dec_in_valid = 1'b0;
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    run_law(1'b0);   // R1: Mu-law selected by 0
    run_law(1'b1);   // R1: A-law selected by 1
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule